// File: doc/BRIEF.md
# Code-Group Synchronization State Machine

This block follows a stream of code groups that are already aligned and already classified upstream. On each clock cycle the block receives three flags: the group is a valid synchronization group, the group is good, or the group is erroneous. A cycle with no flag raised carries no group. From this stream the block keeps a held synchronization level and a two-bit state that a link controller can read directly.

Sync is acquired after an unbroken run of valid synchronization groups reaches the acquisition threshold. Once acquired, sync stays high until erroneous groups reach the loss threshold. Any good group clears this error run, so only errors with no good group between them count toward loss. After loss, the block needs a fresh run of valid synchronization groups before sync rises again. Both thresholds are programmable 8-bit inputs and are read live on every cycle. The block does not detect errors itself; the flags arrive already computed.

Top module: `cg_sync_fsm`

## Requirements
- R1: Each cycle is classified with this priority. `grp_err_i` high makes the cycle an erroneous group. Otherwise `grp_sync_i` high makes it a valid sync group, which also counts as good. Otherwise `grp_good_i` high makes it a good group. With no flag high, the cycle is idle, and it changes neither the state nor any count.
- R2: While `rst_n` is low, the block is held in the unsynchronized state: `sync_o` = 0, `state_o` = 0, and both run counts are zero. Reset takes effect without a clock edge.
- R3: While unsynchronized, each valid sync group extends the acquisition run. `sync_o` rises on the clock edge that accepts the group making the run equal to the effective acquisition threshold. The rise is visible right after that edge.
- R4: While unsynchronized, an erroneous group restarts the acquisition run from zero. A good group that is not a sync group neither extends nor restarts the run.
- R5: Once `sync_o` is high, it stays high on every cycle until the loss condition of R6 is met. After a loss, it stays low until the condition of R3 is met again.
- R6: While synchronized, each erroneous group extends the error run. Idle cycles leave the run unchanged. `sync_o` falls on the edge that accepts the error making the run equal to the effective loss threshold, and both runs are then zero.
- R7: While synchronized, any good group or sync group clears the error run to zero.
- R8: The effective threshold is the programmed 8-bit value, except that a programmed zero acts as one.
- R9: `state_o` encodes the state as follows. 0 means unsynchronized with no acquisition run. 1 means unsynchronized with an acquisition run under way. 2 means synchronized with no pending errors. 3 means synchronized with at least one pending error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_err_i | input | 1 | Current group is erroneous |
| grp_sync_i | input | 1 | Current group is a valid synchronization group |
| grp_good_i | input | 1 | Current group is good |
| acq_thresh_i | input | 8 | Valid sync groups needed to acquire (0 acts as 1) |
| loss_thresh_i | input | 8 | Uninterrupted erroneous groups needed to lose sync (0 acts as 1) |
| sync_o | output | 1 | Held synchronization level |
| state_o | output | 2 | Current state code, see R9 |

## Verification
Two events can fall on the same edge. The first is a group that completes a run, so the state changes. The second is a group whose flags conflict, such as an error raised together with a sync flag. The bench provokes this by raising the error and sync flags together on the group that would finish an acquisition or a loss run. The error must win: it restarts acquisition and counts toward loss. The bench also sets a threshold to zero, so that a single group both starts and completes a run. A behavioural model built on integer counts predicts the level and the state code for every cycle, and the bench compares both against the outputs on each cycle.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_GOOD = 2'd1,
    GRP_SYNC = 2'd2,
    GRP_ERR  = 2'd3
  } grp_kind_e;

  typedef enum logic [1:0] {
    ST_UNSYNC   = 2'd0,
    ST_ACQUIRE  = 2'd1,
    ST_LOCKED   = 2'd2,
    ST_DEGRADED = 2'd3
  } sync_state_e;

endpackage

// File: rtl/cgs_classify.sv
module cgs_classify
  import cgs_pkg::*;
(
  input  logic      err_i,
  input  logic      sync_i,
  input  logic      good_i,
  output grp_kind_e kind_o
);

  // R1: error outranks sync, and sync outranks plain good
  always_comb begin
    if (err_i)       kind_o = GRP_ERR;
    else if (sync_i) kind_o = GRP_SYNC;
    else if (good_i) kind_o = GRP_GOOD;
    else             kind_o = GRP_NONE;
  end

endmodule

// File: rtl/cgs_run_counter.sv
module cgs_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reached_o
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q, count_d;
  logic [EXT_W-1:0] eff_thresh;
  logic [EXT_W-1:0] count_plus;
  logic             cnt_en;

  // R8: a zero threshold acts as one
  always_comb begin
    if (thresh_i == '0) eff_thresh = EXT_W'(1);
    else                eff_thresh = {1'b0, thresh_i};
  end

  assign count_plus = {1'b0, count_q} + EXT_W'(1);
  assign reached_o  = inc_i && (count_plus >= eff_thresh);

  assign cnt_en = inc_i | clr_i;

  always_comb begin
    count_d = count_q;
    if (clr_i)      count_d = '0;
    else if (inc_i) count_d = count_plus[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/cgs_sync_ctrl.sv
module cgs_sync_ctrl
  import cgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  grp_kind_e   kind_i,
  input  logic        acq_reached_i,
  input  logic        loss_reached_i,
  output logic        acq_inc_o,
  output logic        acq_clr_o,
  output logic        err_inc_o,
  output logic        err_clr_o,
  output sync_state_e state_o
);

  sync_state_e state_q, state_d;
  logic        in_sync;

  assign in_sync = (state_q == ST_LOCKED) || (state_q == ST_DEGRADED);

  always_comb begin
    state_d   = state_q;
    acq_inc_o = 1'b0;
    acq_clr_o = 1'b0;
    err_inc_o = 1'b0;
    err_clr_o = 1'b0;
    if (!in_sync) begin
      unique case (kind_i)
        GRP_ERR: begin            // R4 restart
          acq_clr_o = 1'b1;
          state_d   = ST_UNSYNC;
        end
        GRP_SYNC: begin           // R3 extend / acquire
          acq_inc_o = 1'b1;
          if (acq_reached_i) begin
            acq_clr_o = 1'b1;
            err_clr_o = 1'b1;
            state_d   = ST_LOCKED;
          end else begin
            state_d   = ST_ACQUIRE;
          end
        end
        default: state_d = state_q;
      endcase
    end else begin
      unique case (kind_i)
        GRP_ERR: begin            // R6 extend / lose
          err_inc_o = 1'b1;
          if (loss_reached_i) begin
            err_clr_o = 1'b1;
            acq_clr_o = 1'b1;
            state_d   = ST_UNSYNC;
          end else begin
            state_d   = ST_DEGRADED;
          end
        end
        GRP_SYNC, GRP_GOOD: begin // R7 clear error run
          err_clr_o = 1'b1;
          state_d   = ST_LOCKED;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_UNSYNC;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/cg_sync_fsm.sv
module cg_sync_fsm
  import cgs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_err_i,
  input  logic             grp_sync_i,
  input  logic             grp_good_i,
  input  logic [CNT_W-1:0] acq_thresh_i,
  input  logic [CNT_W-1:0] loss_thresh_i,
  output logic             sync_o,
  output logic [1:0]       state_o
);

  grp_kind_e        kind;
  sync_state_e      state;
  logic             acq_inc, acq_clr, err_inc, err_clr;
  logic             acq_reached, loss_reached;
  logic [CNT_W-1:0] acq_cnt, err_cnt;

  cgs_classify u_classify (
    .err_i  (grp_err_i),
    .sync_i (grp_sync_i),
    .good_i (grp_good_i),
    .kind_o (kind)
  );

  cgs_run_counter #(.CNT_W(CNT_W)) u_acq_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh_i  (acq_thresh_i),
    .inc_i     (acq_inc),
    .clr_i     (acq_clr),
    .count_o   (acq_cnt),
    .reached_o (acq_reached)
  );

  cgs_run_counter #(.CNT_W(CNT_W)) u_err_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .thresh_i  (loss_thresh_i),
    .inc_i     (err_inc),
    .clr_i     (err_clr),
    .count_o   (err_cnt),
    .reached_o (loss_reached)
  );

  cgs_sync_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .kind_i         (kind),
    .acq_reached_i  (acq_reached),
    .loss_reached_i (loss_reached),
    .acq_inc_o      (acq_inc),
    .acq_clr_o      (acq_clr),
    .err_inc_o      (err_inc),
    .err_clr_o      (err_clr),
    .state_o        (state)
  );

  assign state_o = state;
  assign sync_o  = state[1];

  assert_acquire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && kind == GRP_SYNC && acq_reached) |=> sync_o);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && kind == GRP_ERR) |=> (acq_cnt == '0 && state_o == 2'd0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && kind != GRP_ERR) |=> sync_o);

  assert_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && kind == GRP_ERR && loss_reached) |=> (!sync_o && err_cnt == '0 && acq_cnt == '0));

  assert_good_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && (kind == GRP_GOOD || kind == GRP_SYNC)) |=> (err_cnt == '0 && state_o == 2'd2));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == GRP_NONE) |=> ($stable(state_o) && $stable(acq_cnt) && $stable(err_cnt)));

  assert_zero_thr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_o && kind == GRP_SYNC && acq_thresh_i == '0) |=> sync_o);

endmodule

// File: tb/cg_sync_fsm_tb.sv
module cg_sync_fsm_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       g_err, g_sync, g_good;
  logic [7:0] acq_thr, loss_thr;
  logic       sync_o;
  logic [1:0] state_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  string cur_req = "R2";

  // reference model state
  int m_acq, m_err;
  bit m_sync;

  always #5 clk = ~clk;

  cg_sync_fsm dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .grp_err_i     (g_err),
    .grp_sync_i    (g_sync),
    .grp_good_i    (g_good),
    .acq_thresh_i  (acq_thr),
    .loss_thresh_i (loss_thr),
    .sync_o        (sync_o),
    .state_o       (state_o)
  );

  function automatic int exp_state();
    if (m_sync) return (m_err > 0) ? 3 : 2;
    return (m_acq > 0) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acq = 0; m_err = 0; m_sync = 0;
    end else begin
      int ea, el;
      ea = (acq_thr == 0) ? 1 : acq_thr;
      el = (loss_thr == 0) ? 1 : loss_thr;
      if (!m_sync) begin
        if (g_err) m_acq = 0;
        else if (g_sync) begin
          m_acq++;
          if (m_acq >= ea) begin m_sync = 1; m_acq = 0; m_err = 0; end
        end
      end else begin
        if (g_err) begin
          m_err++;
          if (m_err >= el) begin m_sync = 0; m_err = 0; m_acq = 0; end
        end else if (g_sync || g_good) m_err = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, sync_o, m_sync, "sync_o model");
      chk(cur_req, state_o, exp_state(), "state_o model");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // kind: 0 idle, 1 good, 2 sync, 3 err, 4 err+sync, 5 sync+good
  task automatic step(int kind);
    g_err  = (kind == 3 || kind == 4);
    g_sync = (kind == 2 || kind == 4 || kind == 5);
    g_good = (kind == 1 || kind == 5);
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(string req, int s, int st);
    chk(req, sync_o, s, "sync_o");
    chk(req, state_o, st, "state_o");
  endtask

  initial begin
    rst_n = 1'b0;
    g_err = 0; g_sync = 0; g_good = 0;
    acq_thr = 8'd4; loss_thr = 8'd3;
    #13;
    expect_out("R2", 0, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
    expect_out("R2", 0, 0);

    // R3: four sync groups needed
    cur_req = "R3";
    step(2); expect_out("R3", 0, 1);
    step(2); step(0); step(2); expect_out("R3", 0, 1);
    step(2); expect_out("R3", 1, 2);

    // R5: held across good and idle groups
    cur_req = "R5";
    step(1); step(0); step(2); step(0);
    expect_out("R5", 1, 2);

    // R7: errors interrupted by a good group do not lose sync
    cur_req = "R7";
    step(3); expect_out("R7", 1, 3);
    step(3); step(1); expect_out("R7", 1, 2);
    step(3); step(3); expect_out("R7", 1, 3);
    step(2); expect_out("R7", 1, 2);

    // R6: idle between errors does not break the run
    cur_req = "R6";
    step(3); step(0); step(3); expect_out("R6", 1, 3);
    step(3); expect_out("R6", 0, 0);
    step(0); step(0); expect_out("R5", 0, 0);

    // R4: error restarts, good does nothing
    cur_req = "R4";
    step(2); step(2); step(2); step(1); expect_out("R4", 0, 1);
    step(3); expect_out("R4", 0, 0);
    step(2); step(2); step(2); expect_out("R4", 0, 1);
    step(2); expect_out("R4", 1, 2);

    // R1: error wins over sync in the completing cycle
    cur_req = "R1";
    step(3); step(3); step(4); expect_out("R1", 0, 0);
    step(2); step(2); step(2); step(4); expect_out("R1", 0, 0);
    step(5); step(5); step(5); step(5); expect_out("R1", 1, 2);
    step(0); expect_out("R1", 1, 2);

    // R8: zero thresholds act as one
    cur_req = "R8";
    acq_thr = 8'd0; loss_thr = 8'd0;
    step(3); expect_out("R8", 0, 0);
    step(2); expect_out("R8", 1, 2);
    step(4); expect_out("R8", 0, 0);

    // R9 plus mixed traffic: random flags, thresholds changed occasionally
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        acq_thr  = 8'($urandom_range(0, 5));
        loss_thr = 8'($urandom_range(0, 5));
      end
      step(int'($urandom_range(0, 5)));
    end
    step(0);

    // async reset mid-run
    cur_req = "R2";
    step(2);
    rst_n = 1'b0;
    #1;
    expect_out("R2", 0, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    step(0);
    expect_out("R2", 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule